// File: doc/BRIEF.md
# Four-Function Arithmetic Logic Unit with Condition Flags

This unit takes two 64-bit operand words and a 2-bit function code. From these it forms a 64-bit result and three condition flags: signed overflow, zero and carry/borrow. The four functions are addition, subtraction, bitwise AND and bitwise XOR. The unit has no clock and holds no state. Every output is a pure function of the present inputs and follows them continuously.

The unit is meant for the execute stage of a simple processor datapath. The surrounding logic decides whether and when the flags are stored. Addition and subtraction share one carry-select adder. Subtraction is formed by inverting the second operand and forcing the carry-in to one. The zero flag comes from a reduction tree over the selected result. The two logic functions clear overflow and carry.

There are no states or transitions: the unit is a combinational path from `op_x`, `op_y` and `fn_sel` to the four outputs. The function code is decoded once into an enumeration (ADD, SUB, AND, XOR), and a unique case on that value steers both the result multiplexer and the flag selection.

Top module: `alu64_core`

## Requirements
- R1: When `fn_sel` is 0, `res` equals `op_x + op_y` modulo 2^64.
- R2: When `fn_sel` is 1, `res` equals `op_x - op_y` modulo 2^64.
- R3: When `fn_sel` is 2, `res` equals the bitwise AND of `op_x` and `op_y`.
- R4: When `fn_sel` is 3, `res` equals the bitwise XOR of `op_x` and `op_y`.
- R5: For every function code, `flag_zero` is 1 exactly when all 64 bits of `res` are 0.
- R6: With code 0, `flag_ovf` is 1 exactly when `op_x[63]` equals `op_y[63]` and `res[63]` differs from them.
- R7: With code 1, `flag_ovf` is 1 exactly when `op_x[63]` differs from `op_y[63]` and `res[63]` differs from `op_x[63]`.
- R8: With code 0, `flag_carry` is the unsigned carry out of bit 63 of the sum.
- R9: With code 1, `flag_carry` is 1 exactly when `op_y` is greater than `op_x` as unsigned numbers (borrow).
- R10: With codes 2 and 3, `flag_ovf` and `flag_carry` are both 0, whatever the operands.
- R11: The outputs change with the inputs and need no clock edge. The values are valid after the inputs change, even away from any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 64 | First operand (minuend for subtraction) |
| op_y | input | 64 | Second operand (subtrahend for subtraction) |
| fn_sel | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| res | output | 64 | Result word |
| flag_ovf | output | 1 | Signed overflow |
| flag_zero | output | 1 | Result is all zeros |
| flag_carry | output | 1 | Carry out on add, borrow on subtract, 0 otherwise |

## Verification
The bench targets the carry chain at its extremes:
- All-ones plus one must wrap to zero with carry set and zero set. A broken chunk-to-chunk carry select leaves stray ones in the upper bits instead.
- The signed limits (largest positive plus one, most negative minus one) must raise overflow. A unit that inverts the operand sign before testing overflow gets subtraction overflow backwards.
- Zero minus one and equal operands test the borrow sense. A unit that passes the raw adder carry through on subtraction reports the opposite borrow.
- Logic functions are driven with operands that would overflow or carry if added, so any flag leaking out of the adder shows on the ports.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
    parameter int WIDTH = 64,
    parameter int CHUNK = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             sgn_ovf
);
    localparam int NCH = WIDTH / CHUNK;

    logic [WIDTH-1:0] b_eff;
    logic [NCH:0]     chain;

    assign b_eff    = b ^ {WIDTH{subtract}};
    assign chain[0] = subtract;

    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        logic [CHUNK:0] s_lo;
        logic [CHUNK:0] s_hi;
        assign s_lo = {1'b0, a[g*CHUNK +: CHUNK]} + {1'b0, b_eff[g*CHUNK +: CHUNK]};
        assign s_hi = {1'b0, a[g*CHUNK +: CHUNK]} + {1'b0, b_eff[g*CHUNK +: CHUNK]}
                      + {{CHUNK{1'b0}}, 1'b1};
        assign sum[g*CHUNK +: CHUNK] = chain[g] ? s_hi[CHUNK-1:0] : s_lo[CHUNK-1:0];
        assign chain[g+1]            = chain[g] ? s_hi[CHUNK] : s_lo[CHUNK];
    end

    assign carry_out = chain[NCH];
    assign sgn_ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) & (sum[WIDTH-1] ^ a[WIDTH-1]);

    always_comb begin
        if (!subtract) begin
            p_chain_sum_r8: assert ({carry_out, sum} == ({1'b0, a} + {1'b0, b}))
                else $error("adder sum/carry mismatch");
        end
    end
endmodule

// File: rtl/alu64_bitwise.sv
module alu64_bitwise #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] and_w,
    output logic [WIDTH-1:0] xor_w
);
    assign and_w = a & b;
    assign xor_w = a ^ b;
endmodule

// File: rtl/alu64_zero_tree.sv
module alu64_zero_tree #(
    parameter int WIDTH = 64,
    parameter int GROUP = 8
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_zero
);
    localparam int NGRP = WIDTH / GROUP;

    logic [NGRP-1:0] grp_any;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign grp_any[g] = |word[g*GROUP +: GROUP];
    end

    assign is_zero = ~|grp_any;
endmodule

// File: rtl/alu64_core.sv
module alu64_core
    import alu64_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int CHUNK = 8,
    parameter int GROUP = 8
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    input  logic [1:0]       fn_sel,
    output logic [WIDTH-1:0] res,
    output logic             flag_ovf,
    output logic             flag_zero,
    output logic             flag_carry
);
    localparam int MSB = WIDTH - 1;

    alu_fn_e          fn;
    logic             is_sub;
    logic [WIDTH-1:0] arith_w;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] and_w;
    logic [WIDTH-1:0] xor_w;
    logic             zero_w;
    alu_flags_t       flags;

    assign fn     = alu_fn_e'(fn_sel);
    assign is_sub = (fn == FN_SUB);

    alu64_addsub #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_addsub (
        .a         (op_x),
        .b         (op_y),
        .subtract  (is_sub),
        .sum       (arith_w),
        .carry_out (arith_c),
        .sgn_ovf   (arith_v)
    );

    alu64_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a     (op_x),
        .b     (op_y),
        .and_w (and_w),
        .xor_w (xor_w)
    );

    always_comb begin
        unique case (fn)
            FN_ADD:  res = arith_w;
            FN_SUB:  res = arith_w;
            FN_AND:  res = and_w;
            FN_XOR:  res = xor_w;
            default: res = '0;
        endcase
    end

    alu64_zero_tree #(.WIDTH(WIDTH), .GROUP(GROUP)) u_zero (
        .word    (res),
        .is_zero (zero_w)
    );

    always_comb begin
        flags.zero = zero_w;
        unique case (fn)
            FN_ADD: begin
                flags.ovf   = arith_v;
                flags.carry = arith_c;
            end
            FN_SUB: begin
                flags.ovf   = arith_v;
                flags.carry = ~arith_c;
            end
            default: begin
                flags.ovf   = 1'b0;
                flags.carry = 1'b0;
            end
        endcase
    end

    assign flag_ovf   = flags.ovf;
    assign flag_zero  = flags.zero;
    assign flag_carry = flags.carry;

    always_comb begin
        if (fn == FN_AND || fn == FN_XOR) begin
            p_logic_flags_clear_r10: assert (!flag_ovf && !flag_carry)
                else $error("logic op raised ovf/carry");
        end
        if (fn == FN_SUB) begin
            p_sub_borrow_r9: assert (flag_carry == (op_y > op_x))
                else $error("borrow flag wrong");
        end
        if (flag_zero) begin
            p_zero_empty_r5: assert (res == '0)
                else $error("zero flag with nonzero result");
        end
        if (fn == FN_XOR) begin
            p_xor_undo_r4: assert ((res ^ op_y) == op_x)
                else $error("xor result cannot be undone");
        end
        if (fn == FN_AND) begin
            p_and_subset_r3: assert (((res & ~op_x) == '0) && ((res & ~op_y) == '0))
                else $error("and result has bit outside operands");
        end
        if (flag_ovf && fn == FN_ADD) begin
            p_add_ovf_signs_r6: assert (op_x[MSB] == op_y[MSB] && res[MSB] != op_x[MSB])
                else $error("add overflow with unfit signs");
        end
        if (flag_ovf && fn == FN_SUB) begin
            p_sub_ovf_signs_r7: assert (op_x[MSB] != op_y[MSB] && res[MSB] != op_x[MSB])
                else $error("sub overflow with unfit signs");
        end
    end
endmodule

// File: tb/sim_alu64_core.sv
module sim_alu64_core;
    logic        clk = 1'b0;
    logic [63:0] op_x = '0;
    logic [63:0] op_y = '0;
    logic [1:0]  fn_sel = '0;
    logic [63:0] res;
    logic        flag_ovf;
    logic        flag_zero;
    logic        flag_carry;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    alu64_core u0 (
        .op_x       (op_x),
        .op_y       (op_y),
        .fn_sel     (fn_sel),
        .res        (res),
        .flag_ovf   (flag_ovf),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic golden(input logic [63:0] x, input logic [63:0] y, input logic [1:0] f,
                          output logic [63:0] r, output logic v, output logic z, output logic c);
        logic [64:0] wide;
        r = '0; v = 1'b0; c = 1'b0;
        case (f)
            2'd0: begin
                wide = {1'b0, x} + {1'b0, y};
                r = wide[63:0];
                c = wide[64];
                v = (x[63] == y[63]) && (r[63] != x[63]);
            end
            2'd1: begin
                r = x - y;
                c = (y > x);
                v = (x[63] != y[63]) && (r[63] != x[63]);
            end
            2'd2: r = x & y;
            default: r = x ^ y;
        endcase
        z = (r == 64'd0);
    endtask

    task automatic apply_check(input logic [63:0] x, input logic [63:0] y,
                               input logic [1:0] f, input string tag);
        logic [63:0] er;
        logic ev, ez, ec;
        @(negedge clk);
        op_x = x; op_y = y; fn_sel = f;
        #1;
        golden(x, y, f, er, ev, ez, ec);
        n_chk = n_chk + 1;
        if (res !== er || flag_ovf !== ev || flag_zero !== ez || flag_carry !== ec) begin
            n_fail = n_fail + 1;
            $display("FAIL %s fn=%0d: actual res=%h v%b z%b c%b expected res=%h v%b z%b c%b",
                     tag, f, res, flag_ovf, flag_zero, flag_carry, er, ev, ez, ec);
        end
    endtask

    task automatic t_idle_inputs;
        apply_check(64'd0, 64'd0, 2'd0, "R5 all-zero add");
        apply_check(64'd0, 64'd0, 2'd2, "R5 all-zero and");
    endtask

    task automatic t_add_edges;
        apply_check(64'd5, 64'd7, 2'd0, "R1 small add");
        apply_check('1, 64'd1, 2'd0, "R8 R5 wrap carry");
        apply_check(64'h7fff_ffff_ffff_ffff, 64'd1, 2'd0, "R6 positive overflow");
        apply_check(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd0, "R6 R8 negative overflow");
        apply_check(64'h0000_0000_ffff_ffff, 64'd1, 2'd0, "R1 mid carry ripple");
    endtask

    task automatic t_sub_edges;
        apply_check(64'd0, 64'd1, 2'd1, "R9 zero minus one borrow");
        apply_check(64'h1234, 64'h1234, 2'd1, "R2 R5 equal operands");
        apply_check(64'h8000_0000_0000_0000, 64'd1, 2'd1, "R7 negative overflow");
        apply_check(64'h7fff_ffff_ffff_ffff, '1, 2'd1, "R7 positive overflow");
        apply_check(64'd100, 64'd30, 2'd1, "R2 plain subtract");
    endtask

    task automatic t_logic_ops;
        apply_check(64'hff00_ff00_ff00_ff00, 64'h00ff_00ff_00ff_00ff, 2'd2, "R3 R5 disjoint and");
        apply_check('1, 64'd1, 2'd2, "R10 and with carry operands");
        apply_check(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd3, "R4 R10 xor sign");
        apply_check(64'hdead_beef_0bad_f00d, 64'hdead_beef_0bad_f00d, 2'd3, "R4 R5 xor self");
        apply_check(64'h7fff_ffff_ffff_ffff, 64'd1, 2'd3, "R10 xor ovf operands");
    endtask

    task automatic t_no_clock_needed;
        logic [63:0] er;
        logic ev, ez, ec;
        @(posedge clk);
        #1;
        op_x = 64'd40; op_y = 64'd2; fn_sel = 2'd0;
        #1;
        golden(64'd40, 64'd2, 2'd0, er, ev, ez, ec);
        n_chk = n_chk + 1;
        if (res !== er) begin
            n_fail = n_fail + 1;
            $display("FAIL R11 first change: actual %h expected %h", res, er);
        end
        fn_sel = 2'd1;
        #1;
        golden(64'd40, 64'd2, 2'd1, er, ev, ez, ec);
        n_chk = n_chk + 1;
        if (res !== er) begin
            n_fail = n_fail + 1;
            $display("FAIL R11 second change: actual %h expected %h", res, er);
        end
    endtask

    task automatic t_sweep;
        logic [63:0] lfsr = 64'hace1_2468_1357_9bdf;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] xa, ya;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            xa = lfsr;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            ya = {lfsr[31:0], lfsr[63:32]};
            apply_check(xa, ya, 2'(i), "R1 R2 R3 R4 R6 R7 R8 R9 sweep");
        end
    endtask

    initial begin
        t_idle_inputs();
        t_add_edges();
        t_sub_edges();
        t_logic_ops();
        t_no_clock_needed();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule